// File: doc/BRIEF.md
# Conditional Trap Comparator

This block decides whether a conditional trap instruction fires. Each cycle that the issue strobe is high, it compares two operands under a 5-bit condition mask. Each mask bit enables one relation: two signed, one equality, two unsigned. If any enabled relation holds, the block raises a program-trap request one clock later. The request carries a fixed trap reason code, and the exception logic downstream uses that code to deliver the program exception.

A build parameter adds a doubleword lane. With that lane present, a per-instruction width select chooses between comparing the low 32 bits and comparing all 64 bits. The same condition encoding applies at both widths. In word mode, only the low word of each operand matters, and bit 31 is the sign bit.

Top module: `trap_cond_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `trap_req` is 0 and `trap_cause` is 4'h0.
- R2: Condition bit 4 (value 5'h10) enables the signed less-than relation, operand A < operand B.
- R3: Condition bit 3 (value 5'h08) enables the signed greater-than relation, A > B.
- R4: Condition bit 2 (value 5'h04) enables the equality relation, A == B.
- R5: Condition bit 1 (value 5'h02) enables unsigned A < B, and condition bit 0 (value 5'h01) enables unsigned A > B.
- R6: The trap fires when at least one enabled relation is true. The relations are combined with OR.
- R7: A condition of 5'h1F always traps, and a condition of 5'h00 never traps.
- R8: `trap_req` is high in the cycle after a cycle with `in_valid` high and a firing condition, and only in that cycle. A cycle with `in_valid` low gives `trap_req` low in the following cycle.
- R9: `trap_cause` equals 4'h2 (trap reason) whenever `trap_req` is 1, and 4'h0 otherwise.
- R10: With `in_wide` = 0, only bits [31:0] of each operand are compared, with bit 31 as the sign. Bits [63:32] have no effect.
- R11: With `in_wide` = 1 (and the doubleword lane enabled), all 64 bits are compared, with bit 63 as the sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A trap instruction is presented this cycle |
| in_wide | input | 1 | 1 = doubleword compare, 0 = word compare |
| op_a | input | DATA_W | First operand |
| op_b | input | DATA_W | Second operand |
| cond | input | 5 | Relation enable mask (bit 4 signed lt, 3 signed gt, 2 eq, 1 unsigned lt, 0 unsigned gt) |
| trap_req | output | 1 | Program-trap request, one cycle after the strobe |
| trap_cause | output | 4 | Reason code, 4'h2 while trap_req is high |

## Verification
The hardest cases to reach are operand pairs where the signed and unsigned orderings disagree, and word-mode pairs whose high words contradict their low words. Random operands almost never produce equal values or opposite signs in the right lane. The stimulus therefore crafts sign-boundary pairs, such as all-ones against one and the most negative value against the most positive. It also builds word-mode pairs whose low words match while the high words differ, and doubleword pairs that are the mirror case. A random phase then copies operand A into B about a quarter of the time, so that equality is exercised under mixed masks.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;

    localparam int COND_W   = 5;
    localparam int CAUSE_W  = 4;

    // Bit positions inside the condition mask (decoded by the instruction format).
    localparam int C_SLT = 4;
    localparam int C_SGT = 3;
    localparam int C_EQ  = 2;
    localparam int C_ULT = 1;
    localparam int C_UGT = 0;

    localparam logic [CAUSE_W-1:0] CAUSE_NONE = 4'h0;
    localparam logic [CAUSE_W-1:0] CAUSE_TRAP = 4'h2;

    typedef struct packed {
        logic                 req;
        logic [CAUSE_W-1:0]   cause;
    } trap_out_t;

endpackage

// File: rtl/trap_rel_eval.sv
module trap_rel_eval
    import trap_cmp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    output logic [COND_W-1:0] rel
);

    logic eq_w;
    logic ult_w;
    logic sign_diff;

    always_comb begin
        eq_w      = (a == b);
        ult_w     = (a < b);
        sign_diff = a[W-1] ^ b[W-1];
        // Signed ordering equals unsigned ordering unless the signs differ,
        // in which case the negative operand is the smaller one.
        rel[C_EQ]  = eq_w;
        rel[C_ULT] = ult_w;
        rel[C_UGT] = !ult_w && !eq_w;
        rel[C_SLT] = sign_diff ? a[W-1] : ult_w;
        rel[C_SGT] = sign_diff ? b[W-1] : (!ult_w && !eq_w);
    end

endmodule

// File: rtl/trap_cond_match.sv
module trap_cond_match
    import trap_cmp_pkg::*;
(
    input  logic [COND_W-1:0] rel,
    input  logic [COND_W-1:0] cond,
    output logic              hit
);

    always_comb begin
        hit = |(rel & cond);
    end

endmodule

// File: rtl/trap_cond_unit.sv
module trap_cond_unit
    import trap_cmp_pkg::*;
#(
    parameter int  WORD_W  = 32,
    parameter bit  WIDE_EN = 1'b1,
    localparam int DATA_W  = WIDE_EN ? 2 * WORD_W : WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_wide,
    input  logic [DATA_W-1:0]   op_a,
    input  logic [DATA_W-1:0]   op_b,
    input  logic [COND_W-1:0]   cond,
    output logic                trap_req,
    output logic [CAUSE_W-1:0]  trap_cause
);

    logic [COND_W-1:0] rel_word;
    logic [COND_W-1:0] rel_sel;
    logic              hit;
    trap_out_t         out_d;
    trap_out_t         out_q;

    trap_rel_eval #(.W(WORD_W)) u_rel_word (
        .a   (op_a[WORD_W-1:0]),
        .b   (op_b[WORD_W-1:0]),
        .rel (rel_word)
    );

    generate
        if (WIDE_EN) begin : g_dbl
            logic [COND_W-1:0] rel_dbl;

            trap_rel_eval #(.W(DATA_W)) u_rel_dbl (
                .a   (op_a),
                .b   (op_b),
                .rel (rel_dbl)
            );

            always_comb begin
                rel_sel = in_wide ? rel_dbl : rel_word;
            end
        end else begin : g_word
            always_comb begin
                rel_sel = rel_word;
            end
        end
    endgenerate

    trap_cond_match u_match (
        .rel  (rel_sel),
        .cond (cond),
        .hit  (hit)
    );

    always_comb begin
        out_d       = '0;
        out_d.req   = in_valid && hit;
        out_d.cause = (in_valid && hit) ? CAUSE_TRAP : CAUSE_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign trap_req   = out_q.req;
    assign trap_cause = out_q.cause;

endmodule

// File: rtl/trap_cond_chk.sv
module trap_cond_chk
    import trap_cmp_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_wide,
    input logic [DATA_W-1:0]   op_a,
    input logic [DATA_W-1:0]   op_b,
    input logic [COND_W-1:0]   cond,
    input logic                trap_req,
    input logic [CAUSE_W-1:0]  trap_cause
);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !trap_req);

    p_all_ones_traps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond == 5'h1F) |=> trap_req);

    p_zero_mask_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond == 5'h00) |=> !trap_req);

    p_cause_on_trap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (trap_cause == CAUSE_TRAP));

    p_cause_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |-> (trap_cause == CAUSE_NONE));

    p_word_eq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_wide && cond == 5'h04 && op_a[31:0] == op_b[31:0])
        |=> trap_req);

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !$past(in_valid)) |-> 1'b0);

endmodule

bind trap_cond_unit trap_cond_chk #(.DATA_W(DATA_W)) u_trap_cond_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_wide    (in_wide),
    .op_a       (op_a),
    .op_b       (op_b),
    .cond       (cond),
    .trap_req   (trap_req),
    .trap_cause (trap_cause)
);

// File: tb/test_trap_cond_unit.sv
`timescale 1ns/1ps
module test_trap_cond_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_wide = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [4:0]  cond = '0;
    logic        trap_req;
    logic [3:0]  trap_cause;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;
    bit    q_exp[$];
    string q_tag[$];

    always #10 clk = ~clk;

    trap_cond_unit i_trap_cond_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_wide    (in_wide),
        .op_a       (op_a),
        .op_b       (op_b),
        .cond       (cond),
        .trap_req   (trap_req),
        .trap_cause (trap_cause)
    );

    function automatic bit ref_fire(logic [63:0] a, logic [63:0] b,
                                    logic [4:0] c, bit wide);
        longint          sa, sb;
        longint unsigned ua, ub;
        if (wide) begin
            sa = longint'(a); sb = longint'(b);
            ua = a;           ub = b;
        end else begin
            sa = longint'($signed(a[31:0]));
            sb = longint'($signed(b[31:0]));
            ua = {32'h0, a[31:0]};
            ub = {32'h0, b[31:0]};
        end
        return (c[4] && sa < sb) || (c[3] && sa > sb) || (c[2] && sa == sb) ||
               (c[1] && ua < ub) || (c[0] && ua > ub);
    endfunction

    task automatic check_out();
        bit    e;
        string t;
        logic [3:0] ec;
        e  = q_exp.pop_front();
        t  = q_tag.pop_front();
        ec = e ? 4'h2 : 4'h0;
        n_checks++;
        if (trap_req !== e || trap_cause !== ec) begin
            n_fails++;
            $display("FAIL %s: trap_req=%b trap_cause=%h expected %b/%h",
                     t, trap_req, trap_cause, e, ec);
        end
    endtask

    task automatic step(bit v, bit w, logic [63:0] a, logic [63:0] b,
                        logic [4:0] c, string tag);
        @(negedge clk);
        check_out();
        in_valid = v; in_wide = w; op_a = a; op_b = b; cond = c;
        q_exp.push_back(v && ref_fire(a, b, c, w));
        q_tag.push_back(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R1: outputs during reset
        repeat (3) @(negedge clk);
        n_checks++;
        if (trap_req !== 1'b0 || trap_cause !== 4'h0) begin
            n_fails++;
            $display("FAIL R1: trap_req=%b trap_cause=%h expected 0/0",
                     trap_req, trap_cause);
        end
        rst_n = 1'b1;
        q_exp.push_back(1'b0);
        q_tag.push_back("R1");

        // R2 signed less-than, across the sign boundary
        step(1, 0, 64'hFFFF_FFFF, 64'h1, 5'h10, "R2");
        step(1, 0, 64'h1, 64'hFFFF_FFFF, 5'h10, "R2");
        step(1, 0, 64'h8000_0000, 64'h7FFF_FFFF, 5'h10, "R2");
        // R3 signed greater-than
        step(1, 0, 64'h7FFF_FFFF, 64'h8000_0000, 5'h08, "R3");
        step(1, 0, 64'h5, 64'h5, 5'h08, "R3");
        // R4 equality
        step(1, 0, 64'h1234_5678, 64'h1234_5678, 5'h04, "R4");
        step(1, 0, 64'h1234_5678, 64'h1234_5679, 5'h04, "R4");
        // R5 unsigned relations disagree with signed ones
        step(1, 0, 64'h1, 64'hFFFF_FFFF, 5'h02, "R5");
        step(1, 0, 64'hFFFF_FFFF, 64'h1, 5'h02, "R5");
        step(1, 0, 64'hFFFF_FFFF, 64'h1, 5'h01, "R5");
        step(1, 0, 64'h3, 64'h3, 5'h01, "R5");
        // R6 OR of selected relations
        step(1, 0, 64'h9, 64'h2, 5'h14, "R6");
        step(1, 0, 64'h9, 64'h2, 5'h15, "R6");
        step(1, 0, 64'hFFFF_FFFE, 64'h2, 5'h12, "R6");
        // R7 all ones / all zeros
        step(1, 0, 64'h42, 64'h17, 5'h1F, "R7");
        step(1, 0, 64'h42, 64'h42, 5'h1F, "R7");
        step(1, 0, 64'h42, 64'h42, 5'h00, "R7");
        step(1, 1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 5'h00, "R7");
        // R8 idle cycles give no trap, and a pulse lasts one cycle
        step(1, 0, 64'h7, 64'h7, 5'h04, "R8");
        step(0, 0, 64'h7, 64'h7, 5'h1F, "R8");
        step(0, 1, 64'h7, 64'h7, 5'h1F, "R8");
        step(1, 0, 64'h7, 64'h7, 5'h1F, "R8");
        step(1, 0, 64'h7, 64'h7, 5'h1F, "R8");
        step(0, 0, 64'h0, 64'h0, 5'h00, "R9");
        // R10 upper word ignored in word mode
        step(1, 0, 64'hAAAA_0000_0000_0005, 64'h5555_0000_0000_0005, 5'h04, "R10");
        step(1, 0, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_0002, 5'h08, "R10");
        step(1, 0, 64'h0000_0001_8000_0000, 64'h0, 5'h10, "R10");
        // R11 full 64-bit compare
        step(1, 1, 64'hAAAA_0000_0000_0005, 64'h5555_0000_0000_0005, 5'h04, "R11");
        step(1, 1, 64'h8000_0000_0000_0000, 64'h1, 5'h10, "R11");
        step(1, 1, 64'h8000_0000_0000_0000, 64'h1, 5'h02, "R11");
        step(1, 1, 64'h0000_0001_0000_0000, 64'hFFFF_FFFF, 5'h01, "R11");
        step(1, 1, 64'h0000_0001_0000_0000, 64'hFFFF_FFFF, 5'h08, "R11");

        // Mixed random phase (R6, R9, R10, R11)
        for (int i = 0; i < 400; i++) begin
            logic [63:0] a;
            logic [63:0] b;
            a = {$urandom(), $urandom()};
            b = {$urandom(), $urandom()};
            if ($urandom_range(3) == 0) b = a;
            if ($urandom_range(3) == 0) b[31:0] = a[31:0];
            if ($urandom_range(4) == 0) b[63] = ~a[63];
            step(($urandom_range(5) != 0), $urandom_range(1) == 1, a, b,
                 5'($urandom_range(31)), "R6");
        end
        step(0, 0, 64'h0, 64'h0, 5'h00, "R8");
        @(negedge clk);
        check_out();
        finish_run();
    end

endmodule